// File: doc/BRIEF.md
# Deglitched Two-Wire Configuration Target

This block is a target on a two-wire I2C-style serial bus. It gives a host access to a small bank of 8-bit configuration registers. A local system clock oversamples both bus lines. Each line goes through a two-flop synchronizer and then a filter that accepts a new level only once that level has held for a fixed number of clocks. All protocol decisions are made on these filtered, delayed copies, never on the raw pins.

A transfer opens with a START. The host then sends a header byte holding a 7-bit target address and a direction bit. The target answers only when the address equals its strap input. A write transfer loads an internal register pointer from its first data byte and stores each later byte at that pointer. A read transfer returns bytes from the pointer. In both directions the pointer advances after every stored or returned byte.

A repeated START reverses direction without releasing the bus. The usual sequence sets the pointer in a write and then reads in the same transfer. The register contents drive the rest of the chip as a flat vector. The target pulls SDA low through an output-enable that the pad turns into an open-drain driver.

Top module: `i2c_cfg_target`

## Requirements
- R1: A change on SCL or SDA is accepted only after the synchronized level has been stable for 3 consecutive system clocks. Pulses of 2 clocks or fewer on either line have no effect on the bits received or on START/STOP detection.
- R2: After reset, `sda_oe` is 0 and every configuration register is 0. Bus clocking before any START is ignored: no acknowledge is given and no register changes.
- R3: START is filtered SDA falling while filtered SCL is high. STOP is filtered SDA rising while filtered SCL is high. A STOP releases SDA and returns the target to idle, where a later header without a new START gets no acknowledge.
- R4: The header byte is sent MSB first as address[6:0] followed by a direction bit (1 = read, 0 = write). When address[6:0] equals `dev_addr`, the target asserts `sda_oe` through the ninth clock. When it differs, the target drives nothing until the next START or STOP, and any data that follows has no effect.
- R5: In a write, the first data byte sets the pointer to its low log2(NUM_REGS) bits. Each later byte is stored at the pointer, and the pointer then increments, wrapping from NUM_REGS-1 to 0. Every data byte is acknowledged.
- R6: In a read, the target returns the register at the pointer, MSB first. Each bit is driven after a filtered SCL falling edge. The pointer increments after each byte, with wrap, and stays in effect across STOP.
- R7: When the host does not acknowledge a read byte (SDA high at the ninth clock), the target stops driving SDA until a START or a STOP.
- R8: A repeated START without a preceding STOP is accepted. A pointer set in a write can be read back straight after it, in the same transfer, in the read direction.
- R9: `sda_oe` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Strapped 7-bit target address |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_regs | output | NUM_REGS*8 | Register bank contents, register i at bits [8*i+7:8*i] |

## Verification
The hardest behaviour to reach from the ports is rejection of narrow pulses. A well-behaved host never produces them, yet a single accepted glitch would shift an extra bit in or fake a START. The host tasks can therefore insert a 2-clock SCL high pulse in the low phase of every bit, and a 2-clock SDA low pulse in the high phase of every 1 bit, while a pointer byte and a data byte are written. The bench then checks that exactly the intended register holds exactly the intended value. The other hard-to-reach state is the post-NACK wait after a read. The bench gets there by declining the last byte of a multi-byte read, then clocking a further byte and checking that the bus reads all ones and `sda_oe` never rose.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WR,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_e;

    typedef enum logic [1:0] {
        ACK_HDR_WR,
        ACK_HDR_RD,
        ACK_DATA
    } ack_kind_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic hdr_hit(input logic [BYTE_W-1:0] hdr,
                                     input logic [ADDR_W-1:0] strap);
        return hdr[BYTE_W-1:1] == strap;
    endfunction

    function automatic logic hdr_is_read(input logic [BYTE_W-1:0] hdr);
        return hdr[0];
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            run_q  <= '0;
            level  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            if (sync_q[SYNC_STAGES-1] != level) begin
                if (run_q == CNT_LAST) begin
                    level <= sync_q[SYNC_STAGES-1];
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.sda      = sda_f;
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
    parameter int NUM_REGS = 16,
    parameter int PTR_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [PTR_W-1:0]      waddr,
    input  logic [7:0]            wdata,
    input  logic [PTR_W-1:0]      raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && (waddr == PTR_W'(i))) begin
                regs[i] <= wdata;
            end
        end
        assign cfg_flat[i*8 +: 8] = regs[i];
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] strap,
    input  logic [7:0]        rdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [7:0]        wdata,
    output logic              sda_oe,
    output tgt_state_e        state
);
    ack_kind_e  kind;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [6:0] txreg;
    logic       first_byte;
    logic       host_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            kind       <= ACK_HDR_WR;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            first_byte <= 1'b0;
            host_ack   <= 1'b0;
            ptr        <= '0;
            we         <= 1'b0;
            waddr      <= '0;
            wdata      <= '0;
            sda_oe     <= 1'b0;
        end else begin
            we <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR: begin
                        if (ev.scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (hdr_hit(shreg, strap)) begin
                                    state      <= ST_ACK;
                                    sda_oe     <= 1'b1;
                                    kind       <= hdr_is_read(shreg) ? ACK_HDR_RD : ACK_HDR_WR;
                                    first_byte <= 1'b1;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else begin
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                                kind   <= ACK_DATA;
                                if (first_byte) begin
                                    ptr        <= shreg[PTR_W-1:0];
                                    first_byte <= 1'b0;
                                end else begin
                                    we    <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= shreg;
                                    ptr   <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= '0;
                            if (kind == ACK_HDR_RD) begin
                                state  <= ST_RD;
                                txreg  <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                            end else begin
                                state  <= ST_WR;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                                ptr    <= ptr + 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                txreg   <= {txreg[5:0], 1'b0};
                                sda_oe  <= ~txreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            host_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (host_ack) begin
                                state   <= ST_RD;
                                bit_cnt <= '0;
                                txreg   <= rdata[6:0];
                                sda_oe  <= ~rdata[7];
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int FILT_LEN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [6:0]            dev_addr,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int PTR_W   = $clog2(NUM_REGS);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_filt;
    logic               scl_f, sda_f;
    bus_ev_t            ev;
    tgt_state_e         state;
    logic [PTR_W-1:0]   ptr;
    logic               we;
    logic [PTR_W-1:0]   waddr;
    logic [7:0]         wdata;
    logic [7:0]         rdata;

    assign line_raw = {sda_in, scl_in};

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (line_raw[i]),
            .level (line_filt[i])
        );
    end

    assign scl_f = line_filt[0];
    assign sda_f = line_filt[1];

    i2c_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .ev    (ev)
    );

    i2c_tgt_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (dev_addr),
        .rdata  (rdata),
        .ptr    (ptr),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .sda_oe (sda_oe),
        .state  (state)
    );

    i2c_cfg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .raddr    (ptr),
        .rdata    (rdata),
        .cfg_flat (cfg_regs)
    );
endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       scl_f,
    input logic       sda_oe,
    input tgt_state_e state,
    input bus_ev_t    ev
);
    // Depths 3..5 match the default two-flop synchronizer and three-clock filter.
    assert_scl_rise_filtered_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_f) |-> ($past(scl_in, 3) && $past(scl_in, 4) && $past(scl_in, 5)));

    assert_scl_fall_filtered_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_f) |-> (!$past(scl_in, 3) && !$past(scl_in, 4) && !$past(scl_in, 5)));

    assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    assert_stop_to_idle_R3: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_oe));

    assert_start_to_addr_R3: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR));

    assert_wait_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sda_oe);

    assert_drive_change_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f);
endmodule

bind i2c_cfg_target i2c_cfg_target_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_in (scl_in),
    .scl_f  (scl_f),
    .sda_oe (sda_oe),
    .state  (state),
    .ev     (ev)
);

// File: tb/tb_i2c_cfg_target.sv
`timescale 1ns/1ps
module tb_i2c_cfg_target;
    localparam int NUM_REGS = 16;
    localparam int Q        = 10;
    localparam logic [6:0] MY_ADDR = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NUM_REGS*8-1:0] cfg_regs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit oe_seen = 1'b0;
    bit oe_prev = 1'b0;
    int r9_viol = 0;

    always #4 clk = ~clk;

    assign sda_bus = host_sda & ~sda_oe;

    i2c_cfg_target #(.NUM_REGS(NUM_REGS)) dut (
        .clk      (clk),
        .rst      (rst),
        .dev_addr (MY_ADDR),
        .scl_in   (host_scl),
        .sda_in   (sda_bus),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    always @(negedge clk) begin
        if (sda_oe) oe_seen = 1'b1;
        if (!rst && (sda_oe != oe_prev) && host_scl) r9_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int reg_at(input int i);
        return int'(cfg_regs[i*8 +: 8]);
    endfunction

    task automatic send_bit(input logic b, input bit glitch);
        tick(Q);
        host_sda = b;
        if (glitch) begin
            tick(3); host_scl = 1'b1; tick(2); host_scl = 1'b0; tick(Q - 5);
        end else begin
            tick(Q);
        end
        host_scl = 1'b1;
        if (glitch && b) begin
            tick(5); host_sda = 1'b0; tick(2); host_sda = 1'b1; tick(2*Q - 7);
        end else begin
            tick(2*Q);
        end
        host_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(Q); host_sda = 1'b1;
        tick(Q); host_scl = 1'b1;
        tick(Q); b = sda_bus;
        tick(Q); host_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack, 1'b0);
    endtask

    task automatic start_cond();
        if (!host_scl) begin
            tick(Q); host_sda = 1'b1;
            tick(Q); host_scl = 1'b1;
            tick(2*Q);
        end
        host_sda = 1'b0;
        tick(2*Q);
        host_scl = 1'b0;
    endtask

    task automatic stop_cond();
        tick(Q); host_sda = 1'b0;
        tick(Q); host_scl = 1'b1;
        tick(2*Q); host_sda = 1'b1;
        tick(2*Q);
    endtask

    task automatic t_reset();
        chk("R2 sda_oe after reset", int'(sda_oe), 0);
        chk("R2 regs zero after reset", int'(cfg_regs == '0), 1);
    endtask

    task automatic t_no_start();
        logic a;
        host_scl = 1'b0;
        tick(Q);
        oe_seen = 1'b0;
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        send_byte(8'h02, 1'b0, a);
        send_byte(8'h99, 1'b0, a);
        chk("R2 no ack without START", int'(oe_seen), 0);
        stop_cond();
        chk("R2 regs unchanged without START", int'(cfg_regs == '0), 1);
    endtask

    task automatic t_wrong_addr();
        logic a;
        start_cond();
        oe_seen = 1'b0;
        send_byte({7'h11, 1'b0}, 1'b0, a);
        chk("R4 mismatched header not acked", int'(a), 0);
        send_byte(8'h03, 1'b0, a);
        send_byte(8'h77, 1'b0, a);
        chk("R4 no drive after mismatch", int'(oe_seen), 0);
        stop_cond();
        chk("R4 mismatched data has no effect", int'(cfg_regs == '0), 1);
    endtask

    task automatic t_write_burst();
        logic a;
        start_cond();
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        chk("R4 matching header acked after START (R3)", int'(a), 1);
        send_byte(8'h03, 1'b0, a);
        chk("R5 pointer byte acked", int'(a), 1);
        send_byte(8'hA1, 1'b0, a);
        chk("R5 data byte 0 acked", int'(a), 1);
        send_byte(8'hB2, 1'b0, a);
        chk("R5 data byte 1 acked", int'(a), 1);
        send_byte(8'hC3, 1'b0, a);
        chk("R5 data byte 2 acked", int'(a), 1);
        stop_cond();
        chk("R5 reg3", reg_at(3), 'hA1);
        chk("R5 reg4", reg_at(4), 'hB2);
        chk("R5 reg5", reg_at(5), 'hC3);
        chk("R5 reg2 untouched", reg_at(2), 0);
        chk("R3 sda released after STOP", int'(sda_oe), 0);
    endtask

    task automatic t_write_wrap();
        logic a;
        start_cond();
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        send_byte(8'h1F, 1'b0, a);
        send_byte(8'h11, 1'b0, a);
        send_byte(8'h22, 1'b0, a);
        stop_cond();
        chk("R5 pointer low bits, reg15", reg_at(15), 'h11);
        chk("R5 pointer wraps to reg0", reg_at(0), 'h22);
    endtask

    task automatic t_glitch();
        logic a;
        start_cond();
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        send_byte(8'h07, 1'b1, a);
        chk("R1 glitched pointer byte acked", int'(a), 1);
        send_byte(8'h5D, 1'b1, a);
        chk("R1 glitched data byte acked", int'(a), 1);
        stop_cond();
        chk("R1 reg7 exact despite glitches", reg_at(7), 'h5D);
        chk("R1 reg8 untouched", reg_at(8), 0);
        chk("R1 reg6 untouched", reg_at(6), 0);
    endtask

    task automatic t_rep_start_read();
        logic a;
        logic [7:0] d;
        start_cond();
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        send_byte(8'h03, 1'b0, a);
        start_cond();
        send_byte({MY_ADDR, 1'b1}, 1'b0, a);
        chk("R8 read header acked after repeated START", int'(a), 1);
        recv_byte(d, 1'b1);
        chk("R6 R8 read reg3", int'(d), 'hA1);
        recv_byte(d, 1'b1);
        chk("R6 read reg4", int'(d), 'hB2);
        recv_byte(d, 1'b0);
        chk("R6 read reg5", int'(d), 'hC3);
        oe_seen = 1'b0;
        recv_byte(d, 1'b0);
        chk("R7 bus idle-high after NACK", int'(d), 'hFF);
        chk("R7 no drive after NACK", int'(oe_seen), 0);
        stop_cond();
    endtask

    task automatic t_read_wrap();
        logic a;
        logic [7:0] d;
        start_cond();
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        send_byte(8'h0F, 1'b0, a);
        stop_cond();
        start_cond();
        send_byte({MY_ADDR, 1'b1}, 1'b0, a);
        recv_byte(d, 1'b1);
        chk("R6 pointer kept across STOP, reg15", int'(d), 'h11);
        recv_byte(d, 1'b0);
        chk("R6 read pointer wraps to reg0", int'(d), 'h22);
        stop_cond();
    endtask

    task automatic t_idle_after_stop();
        logic a;
        host_scl = 1'b0;
        tick(Q);
        send_byte({MY_ADDR, 1'b0}, 1'b0, a);
        chk("R3 no ack after STOP without new START", int'(a), 0);
        stop_cond();
        chk("R9 drive changes only with SCL low", r9_viol, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_no_start();
        t_wrong_addr();
        t_write_burst();
        t_write_wrap();
        t_glitch();
        t_rep_start_read();
        t_read_wrap();
        t_idle_after_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule